// File: doc/BRIEF.md
# BCD Timekeeping Register File

This block is a real-time clock core. A chain of BCD counters holds seconds, minutes, hours, day of week, date, month, year and century, and it advances once per one-cycle pulse on `tick`, the 1 Hz time base. Software never sees these counters directly. It sees a bank of eight holding registers through a synchronous SRAM-style port with active-low chip, write and output enables. The holding registers take a copy of the counters one cycle after each advance.

Two control bits in the century register change how the copy works. A read-freeze bit stops the copy so that software reads one consistent time, while the counters keep running underneath. A set-time bit also stops the copy, so software can place a new 24-hour BCD time in the holding registers. When that bit is cleared, the loaded values move into the counters. The MSB of the seconds register is an oscillator-stop bit that gates the time base. The port has no back-pressure: every access completes in the cycle it is presented.

Register map, by address: 0 seconds (bit 7 oscillator stop, bits 6:0 BCD 00–59), 1 minutes, 2 hours (BCD 00–23), 3 day of week (1–7), 4 date, 5 month (01–12), 6 year (00–99), 7 control/century (bit 7 set-time, bit 6 read-freeze, bits 5:0 BCD century). Bits outside each field are written as 0 and read as 0.

Top module: `rtc_regfile`

## Requirements
- R1: `dq_en` is 1 only while `ce_n`=0, `we_n`=1 and `oe_n`=0, and `dq_o` then shows the register at `addr`. A write takes place at a rising clock edge that sees `ce_n`=0 and `we_n`=0.
- R2: After reset the time reads 00:00:00, day 1, date 01, month 01, year 00, and the control register reads 0x20 (both control bits 0, century 20).
- R3: Each `tick` pulse seen while the oscillator runs advances the counters by one second. When no freeze applies, all holding registers load the counters together in the following cycle.
- R4: Seconds and minutes roll from 59 to 00 with a carry, hours roll from 23 to 00, and day of week rolls from 7 to 1 when the hour wraps.
- R5: Date rolls over after the month's last day: 30 for months 04, 06, 09 and 11; 31 for the other months; 29 for month 02 in a leap year and 28 otherwise. A year is a leap year when its full four-digit value is divisible by 4, except a year 00 whose century is not divisible by 4. Month rolls from 12 to 01, and year rolls from 99 to 00 and increments the century.
- R6: While read-freeze (control bit 6) is 1, the holding registers keep their values, and the counters go on advancing on each tick.
- R7: After read-freeze is cleared, no refresh happens until the bit has been 0 for `DWELL_CYC` cycles. The first tick after that refreshes every field.
- R8: While set-time (control bit 7) is 1, the holding registers are not refreshed. The cycle after the bit goes from 1 to 0, the counters load the holding-register contents.
- R9: While seconds bit 7 is 1, ticks do not advance the counters. Clearing the bit lets them advance again.
- R10: The control bits read back as last written. A time field written while neither control bit is set reads back the written value until the next refresh replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 3 | Register address |
| dq_i | input | 8 | Write data |
| dq_o | output | 8 | Read data |
| dq_en | output | 1 | Read-data drive enable; when 0 the bus is high-impedance |

## Verification
A carry chain that goes wrong stays hidden until a tick crosses that boundary. It then shows in the read value two cycles after the tick, so the bench steps the counters across each wrap of R4 and R5. A control bit stuck high shows as holding registers that stop changing. That is only visible once a tick has moved the counters and the bench reads again. A broken load path shows on the first read after set-time is cleared and a tick has passed. A dwell counter that is never restarted shows as a refresh on the first tick after read-freeze is cleared, which is earlier than R7 allows.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DW = 8;
  localparam int NREG = 8;
  localparam int AW = $clog2(NREG);

  // Packed with seconds in the least significant byte, so that
  // register address a sits at bits [a*DW +: DW].
  typedef struct packed {
    logic [DW-1:0] cen;
    logic [DW-1:0] yr;
    logic [DW-1:0] mon;
    logic [DW-1:0] date;
    logic [DW-1:0] day;
    logic [DW-1:0] hr;
    logic [DW-1:0] min;
    logic [DW-1:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RESET_TIME = '{cen: 8'h20, yr: 8'h00, mon: 8'h01,
    date: 8'h01, day: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [DW-1:0] field_mask(input logic [AW-1:0] a);
    case (a)
      3'd0: return 8'hFF;
      3'd1: return 8'h7F;
      3'd2: return 8'h3F;
      3'd3: return 8'h07;
      3'd4: return 8'h3F;
      3'd5: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // Time fields only, with the control bits stripped off.
  function automatic rtc_time_t time_only(input rtc_time_t t);
    rtc_time_t r;
    r = t;
    r.sec[7] = 1'b0;
    r.cen[7:6] = 2'b00;
    return r;
  endfunction

  function automatic logic [DW-1:0] bcd_next(input logic [DW-1:0] v,
                                             input logic [DW-1:0] lo,
                                             input logic [DW-1:0] hi);
    if (v == hi) return lo;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [DW-1:0] bcd2bin(input logic [DW-1:0] v);
    return {4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]};
  endfunction

  function automatic logic [DW-1:0] month_last(input logic [DW-1:0] mon,
                                               input logic [DW-1:0] yr,
                                               input logic [DW-1:0] cen);
    logic [DW-1:0] yb, cb;
    logic leap;
    yb = bcd2bin(yr);
    cb = bcd2bin(cen);
    leap = (yb[1:0] == 2'd0) && ((yb != 8'd0) || (cb[1:0] == 2'd0));
    case (mon)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cnt
);
  rtc_time_t nxt;
  logic [DW-1:0] last_day;

  assign last_day = month_last(cnt.mon, cnt.yr, cnt.cen);

  always_comb begin
    nxt = cnt;
    if (adv) begin
      nxt.sec = bcd_next(cnt.sec, 8'h00, 8'h59);
      if (cnt.sec == 8'h59) begin
        nxt.min = bcd_next(cnt.min, 8'h00, 8'h59);
        if (cnt.min == 8'h59) begin
          nxt.hr = bcd_next(cnt.hr, 8'h00, 8'h23);
          if (cnt.hr == 8'h23) begin
            nxt.day  = bcd_next(cnt.day, 8'h01, 8'h07);
            nxt.date = bcd_next(cnt.date, 8'h01, last_day);
            if (cnt.date == last_day) begin
              nxt.mon = bcd_next(cnt.mon, 8'h01, 8'h12);
              if (cnt.mon == 8'h12) begin
                nxt.yr = bcd_next(cnt.yr, 8'h00, 8'h99);
                if (cnt.yr == 8'h99) nxt.cen = bcd_next(cnt.cen, 8'h00, 8'h39);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= RESET_TIME;
    else if (load) cnt <= time_only(load_val);
    else           cnt <= nxt;
  end

  // R3
  property adv_moves_p;
    @(posedge clk) disable iff (!rst_n) (adv && !load) |=> (cnt != $past(cnt));
  endproperty
  adv_moves_chk: assert property (adv_moves_p);
endmodule

// File: rtl/rtc_bus.sv
module rtc_bus
  import rtc_pkg::*;
#(
  parameter int DWELL_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_en,
  input  rtc_time_t     cnt,
  input  logic          adv,
  output rtc_time_t     usr,
  output logic          osc_stop,
  output logic          load_go
);
  localparam int QW = $clog2(DWELL_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(DWELL_CYC);

  logic wstb, wr_bit, rd_bit, wr_d, pend, refresh;
  logic [QW-1:0] quiet;
  rtc_time_t usr_n;
  logic [NREG*DW-1:0] flat;

  assign wstb     = !ce_n && !we_n;
  assign wr_bit   = usr.cen[7];
  assign rd_bit   = usr.cen[6];
  assign osc_stop = usr.sec[7];
  assign load_go  = wr_d && !wr_bit;
  assign refresh  = pend && !wr_bit && !rd_bit && (quiet == QMAX) && !load_go;

  always_comb begin
    usr_n = usr;
    if (refresh) begin
      usr_n = cnt;
      usr_n.sec[7]   = usr.sec[7];
      usr_n.cen[7:6] = usr.cen[7:6];
    end
    flat = usr_n;
    if (wstb) flat[addr*DW +: DW] = dq_i & field_mask(addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      usr   <= RESET_TIME;
      wr_d  <= 1'b0;
      pend  <= 1'b0;
      quiet <= QMAX;
    end else begin
      usr  <= rtc_time_t'(flat);
      wr_d <= wr_bit;
      pend <= adv;
      if (rd_bit)              quiet <= '0;
      else if (quiet != QMAX)  quiet <= quiet + 1'b1;
    end
  end

  assign dq_en = !ce_n && we_n && !oe_n;
  assign dq_o  = usr[addr*DW +: DW];

  // R6
  property halt_freeze_p;
    @(posedge clk) disable iff (!rst_n) ((wr_bit || rd_bit) && !wstb) |=> $stable(usr);
  endproperty
  halt_freeze_chk: assert property (halt_freeze_p);

  // R7
  property dwell_p;
    @(posedge clk) disable iff (!rst_n) ($fell(rd_bit) && !wstb) |=> $stable(usr);
  endproperty
  dwell_chk: assert property (dwell_p);

  // R10
  property ctrl_rb_p;
    @(posedge clk) disable iff (!rst_n)
      (wstb && addr == AW'(NREG - 1)) |=> (usr.cen[7:6] == $past(dq_i[7:6]));
  endproperty
  ctrl_rb_chk: assert property (ctrl_rb_p);
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int DWELL_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_en
);
  rtc_time_t cnt, usr;
  logic osc_stop, load_go, adv;

  assign adv = tick && !osc_stop;

  rtc_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(load_go),
    .load_val(usr), .cnt(cnt)
  );

  rtc_bus #(.DWELL_CYC(DWELL_CYC)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en),
    .cnt(cnt), .adv(adv), .usr(usr), .osc_stop(osc_stop), .load_go(load_go)
  );

  // R8
  property load_p;
    @(posedge clk) disable iff (!rst_n) $fell(usr.cen[7]) |=> (cnt == time_only($past(usr)));
  endproperty
  load_chk: assert property (load_p);

  // R9
  property stop_hold_p;
    @(posedge clk) disable iff (!rst_n) (osc_stop && !load_go) |=> $stable(cnt);
  endproperty
  stop_hold_chk: assert property (stop_hold_p);
endmodule

// File: tb/sim_rtc_regfile.sv
module sim_rtc_regfile;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] dq_i = '0, dq_o;
  logic dq_en;
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  rtc_regfile #(.DWELL_CYC(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en)
  );

  // Monitor: pops an expected read value whenever the bus drives
  always @(negedge clk) begin
    if (dq_en === 1'b1) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R1 unexpected drive: actual %h expected no drive", dq_o);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (dq_o !== e) begin
          nfail++;
          $display("FAIL %s: actual %h expected %h", t, dq_o, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    ce_n = 0; we_n = 0; addr = a; dq_i = d;
    cyc(1);
    ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    ce_n = 0; oe_n = 0; addr = a;
    cyc(1);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic tk;
    tick = 1; cyc(1); tick = 0; cyc(2);
  endtask

  task automatic pin(input logic act, input logic e, input string t);
    nchk++;
    if (act !== e) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic set_time(input logic [7:0] cen, yr, mon, date, day, hr, mn, sec);
    wr(7, 8'h80 | cen);
    wr(0, sec); wr(1, mn); wr(2, hr); wr(3, day);
    wr(4, date); wr(5, mon); wr(6, yr);
    wr(7, cen);
    cyc(2);
  endtask

  initial begin
    repeat (PERIOD * 20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    // R2 reset state
    rd(7, 8'h20, "R2 control");
    rd(0, 8'h00, "R2 seconds");
    rd(4, 8'h01, "R2 date");
    rd(3, 8'h01, "R2 day");
    // R1 bus truth table
    ce_n = 1; oe_n = 0; #1; pin(dq_en, 1'b0, "R1 deselect");
    ce_n = 0; oe_n = 1; #1; pin(dq_en, 1'b0, "R1 oe high");
    oe_n = 0; we_n = 0; #1; pin(dq_en, 1'b0, "R1 write no drive");
    we_n = 1; #1; pin(dq_en, 1'b1, "R1 read drives");
    ce_n = 1; oe_n = 1; cyc(1);
    // R8 load, R4 and R5 leap rollover
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
    rd(0, 8'h58, "R8 loaded seconds");
    tk; rd(0, 8'h59, "R3 one second");
    tk;
    rd(0, 8'h00, "R4 seconds wrap"); rd(1, 8'h00, "R4 minutes wrap");
    rd(2, 8'h00, "R4 hours wrap");   rd(3, 8'h01, "R4 day 7 to 1");
    rd(4, 8'h29, "R5 leap Feb 29");  rd(5, 8'h02, "R5 month kept");
    // R6 read-freeze, R7 dwell
    wr(7, 8'h60); rd(7, 8'h60, "R10 control readback");
    tk; tk; rd(0, 8'h00, "R6 frozen");
    wr(7, 8'h20); tk; rd(0, 8'h00, "R7 within dwell");
    cyc(10); tk; rd(0, 8'h04, "R6 counters kept running");
    rd(4, 8'h29, "R7 date refreshed");
    // R8 set-time halts refresh
    wr(7, 8'hA0); tk; rd(0, 8'h04, "R8 halted");
    wr(7, 8'h20); cyc(2);
    // R5 non-leap Feb
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    tk; rd(4, 8'h01, "R5 non-leap date"); rd(5, 8'h03, "R5 to March");
    // R5 30-day month
    set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    tk; rd(4, 8'h01, "R5 April end"); rd(5, 8'h05, "R5 to May");
    // R5 year and century carry
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    tk; rd(6, 8'h00, "R5 year wrap"); rd(5, 8'h01, "R5 month wrap");
    rd(7, 8'h21, "R5 century carry");
    // R5 year 00 of century 21 is not leap
    set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tk; rd(4, 8'h01, "R5 century non-leap");
    // R9 oscillator stop (counters now 00:00:00)
    wr(0, 8'h80); tk; tk;
    rd(0, 8'h80, "R9 stopped"); rd(1, 8'h00, "R9 minutes held");
    wr(0, 8'h00); tk; rd(0, 8'h01, "R9 restarted");
    // R10 time write without halt is replaced at refresh
    wr(1, 8'h45); rd(1, 8'h45, "R10 written value");
    tk; rd(1, 8'h00, "R10 overwritten");
    cyc(3);
    if (exp_q.size() != 0) begin
      nchk++; nfail++;
      $display("FAIL R1 missing reads: actual %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule